// File: doc/BRIEF.md
# Radix-4 Decimation-in-Frequency Butterfly Datapath

This block computes one radix-4 decimation-in-frequency butterfly per clock on four complex fixed-point samples. The samples are packed words holding a real and an imaginary half. The input differences are rotated by ±j and combined into four pre-twiddle terms. The first term leaves the block unchanged. Each of the other three terms is multiplied by its own complex twiddle factor, given as a Q15 cosine and sine pair with W = C − jS.

Each 16x16 product is rounded and rescaled to Q15 before the real and imaginary parts are combined. A final-stage input treats every twiddle as exactly 1, so the pre-twiddle terms pass through without multiplication. The block is fully pipelined: it accepts a new butterfly on every cycle in which ready is high, and the results appear a fixed number of cycles later. Sample memory, twiddle storage, addressing and block scaling between stages are handled outside this block.

Top module: `r4_dif_bfly`

## Requirements
- R1: While reset is asserted, and until the first clock edge after reset is released, in_ready and out_valid are 0. From that edge on, in_ready stays 1.
- R2: Output A equals the four-input sum. Its real part is xa+xb+xc+xd and its imaginary part is ya+yb+yc+yd. No twiddle factor is applied to it in either mode.
- R3: The pre-twiddle term of output B has real part P=xa+yb−xc−yd and imaginary part Q=ya−xb−yc+xd.
- R4: The pre-twiddle term of output C has real part P=xa−xb+xc−xd and imaginary part Q=ya−yb+yc−yd.
- R5: The pre-twiddle term of output D has real part P=xa−yb−xc+yd and imaginary part Q=ya+xb−yc−xd.
- R6: When final_stage is 0, outputs B, C and D take real part rm(P,C)+rm(Q,S) and imaginary part rm(Q,C)−rm(P,S), using that output's own twiddle factor. rm forms the signed 32-bit product, adds product bit 15 to bits 31..16, and doubles the result, keeping 16 bits. If both C and S are zero, the output is zero.
- R7: When final_stage is 1, outputs B, C and D equal their pre-twiddle terms, and the twiddle inputs have no effect.
- R8: All sums, differences and the final combination are 16-bit two's complement and wrap on overflow, with no saturation.
- R9: A butterfly presented with in_valid=1 while in_ready=1 produces exactly one out_valid pulse, four cycles later. Butterflies may arrive back to back. No other cycle raises out_valid.
- R10: A sample word holds the real part in bits 31..16 and the imaginary part in bits 15..0. A twiddle word holds C in bits 31..16 and S in bits 15..0. Both values are signed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input butterfly present |
| in_ready | output | 1 | Block accepts input this cycle |
| final_stage | input | 1 | 1: treat all twiddles as unity |
| in_a | input | 32 | Sample x(n), packed re/im |
| in_b | input | 32 | Sample x(n+N/4) |
| in_c | input | 32 | Sample x(n+N/2) |
| in_d | input | 32 | Sample x(n+3N/4) |
| tw_b | input | 32 | Twiddle for output B, packed C/S |
| tw_c | input | 32 | Twiddle for output C |
| tw_d | input | 32 | Twiddle for output D |
| out_valid | output | 1 | Output butterfly present |
| out_a | output | 32 | Output A, packed re/im |
| out_b | output | 32 | Output B |
| out_c | output | 32 | Output C |
| out_d | output | 32 | Output D |

## Verification
The bench builds the block with its default widths of 16-bit sample halves and 16-bit Q15 twiddles. These widths make the rounding rule on bit 15 and the 16-bit wrap directly observable. Random full-range samples and twiddles reach products whose bit 15 is set and unset, and sums that overflow. Directed items cover a near-unity cosine, zero twiddles and saturating-range inputs in final-stage mode. Streams that alternate back-to-back items with idle gaps exercise the fixed four-cycle latency under full throughput.

// File: rtl/r4_bfly_pkg.sv
package r4_bfly_pkg;

   // number of butterfly legs
   localparam int unsigned LEGS = 4;

   // per-leg twiddle treatment chosen at elaboration
   typedef enum logic {
      LEG_ROTATE = 1'b0,
      LEG_UNITY  = 1'b1
   } leg_kind_e;

   function automatic leg_kind_e leg_kind(input int unsigned idx);
      return (idx == 0) ? LEG_UNITY : LEG_ROTATE;
   endfunction

endpackage

// File: rtl/r4_bfly_delay.sv
module r4_bfly_delay #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("r4_bfly_delay: DEPTH must be at least 1");
   end
   if (W < 1) begin : g_bad_width
      $error("r4_bfly_delay: W must be at least 1");
   end

   logic [W-1:0] tap [DEPTH+1];
   assign tap[0] = d;

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) tap[i+1] <= '0;
         else        tap[i+1] <= tap[i];
      end
   end

   assign q = tap[DEPTH];

endmodule

// File: rtl/r4_bfly_presum.sv
module r4_bfly_presum #(
   parameter int unsigned DW = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                v_in,
   input  logic [2*DW-1:0]     a,
   input  logic [2*DW-1:0]     b,
   input  logic [2*DW-1:0]     c,
   input  logic [2*DW-1:0]     d,
   output logic                v_out,
   output logic [3:0][DW-1:0]  pre_re,
   output logic [3:0][DW-1:0]  pre_im
);

   localparam int unsigned RH = 2*DW-1;   // top of real half
   localparam int unsigned RL = DW;       // bottom of real half
   localparam int unsigned IH = DW-1;     // top of imaginary half

   // first level: pairwise sums and differences of legs (a,c) and (b,d)
   logic          v1;
   logic [DW-1:0] sac_r, sac_i, dac_r, dac_i;
   logic [DW-1:0] sbd_r, sbd_i, dbd_r, dbd_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1    <= 1'b0;
         sac_r <= '0; sac_i <= '0; dac_r <= '0; dac_i <= '0;
         sbd_r <= '0; sbd_i <= '0; dbd_r <= '0; dbd_i <= '0;
      end else begin
         v1    <= v_in;
         sac_r <= a[RH:RL] + c[RH:RL];
         sac_i <= a[IH:0]  + c[IH:0];
         dac_r <= a[RH:RL] - c[RH:RL];
         dac_i <= a[IH:0]  - c[IH:0];
         sbd_r <= b[RH:RL] + d[RH:RL];
         sbd_i <= b[IH:0]  + d[IH:0];
         dbd_r <= b[RH:RL] - d[RH:RL];
         dbd_i <= b[IH:0]  - d[IH:0];
      end
   end

   // second level: the (b-d) difference is rotated by -j for leg 1, +j for leg 3
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_out  <= 1'b0;
         pre_re <= '0;
         pre_im <= '0;
      end else begin
         v_out     <= v1;
         pre_re[0] <= sac_r + sbd_r;
         pre_im[0] <= sac_i + sbd_i;
         pre_re[1] <= dac_r + dbd_i;
         pre_im[1] <= dac_i - dbd_r;
         pre_re[2] <= sac_r - sbd_r;
         pre_im[2] <= sac_i - sbd_i;
         pre_re[3] <= dac_r - dbd_i;
         pre_im[3] <= dac_i + dbd_r;
      end
   end

endmodule

// File: rtl/r4_bfly_lane.sv
module r4_bfly_lane
   import r4_bfly_pkg::*;
#(
   parameter int unsigned DW   = 16,
   parameter int unsigned TW   = 16,
   parameter leg_kind_e   KIND = LEG_ROTATE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          v_in,
   input  logic          fin_in,
   input  logic [DW-1:0] p_in,
   input  logic [DW-1:0] q_in,
   input  logic [TW-1:0] c_in,
   input  logic [TW-1:0] s_in,
   output logic          v_out,
   output logic [DW-1:0] re_out,
   output logic [DW-1:0] im_out
);

   localparam int unsigned PW = DW + TW;   // full product width

   if (DW < 4) begin : g_bad_dw
      $error("r4_bfly_lane: DW must be at least 4");
   end
   if (TW < 2) begin : g_bad_tw
      $error("r4_bfly_lane: TW must be at least 2");
   end

   logic v3;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v3    <= 1'b0;
         v_out <= 1'b0;
      end else begin
         v3    <= v_in;
         v_out <= v3;
      end
   end

   if (KIND == LEG_UNITY) begin : g_unity
      logic [DW-1:0] p3, q3;
      logic          unused_tw;
      assign unused_tw = ^{c_in, s_in, fin_in};

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            p3 <= '0; q3 <= '0; re_out <= '0; im_out <= '0;
         end else begin
            p3     <= p_in;
            q3     <= q_in;
            re_out <= p3;
            im_out <= q3;
         end
      end
   end else begin : g_rotate
      // signed multiply of sign-extended operands, truncated to PW bits
      function automatic logic [PW-1:0] smul(input logic [DW-1:0] x,
                                              input logic [TW-1:0] y);
         logic [PW-1:0] xe, ye;
         xe = {{TW{x[DW-1]}}, x};
         ye = {{DW{y[TW-1]}}, y};
         return xe * ye;
      endfunction

      // round on the bit below the kept field, then double for Q-format
      function automatic logic [DW-1:0] rnd(input logic [PW-1:0] pr);
         logic [DW-1:0] hi;
         hi = pr[PW-1:TW] + {{(DW-1){1'b0}}, pr[TW-1]};
         return {hi[DW-2:0], 1'b0};
      endfunction

      logic [DW-1:0] pc3, qs3, qc3, ps3, p3, q3;
      logic          fin3;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pc3 <= '0; qs3 <= '0; qc3 <= '0; ps3 <= '0;
            p3  <= '0; q3  <= '0; fin3 <= 1'b0;
         end else begin
            pc3  <= rnd(smul(p_in, c_in));
            qs3  <= rnd(smul(q_in, s_in));
            qc3  <= rnd(smul(q_in, c_in));
            ps3  <= rnd(smul(p_in, s_in));
            p3   <= p_in;
            q3   <= q_in;
            fin3 <= fin_in;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            re_out <= '0;
            im_out <= '0;
         end else if (fin3) begin
            re_out <= p3;
            im_out <= q3;
         end else begin
            re_out <= pc3 + qs3;
            im_out <= qc3 - ps3;
         end
      end

      // R7
      bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (v_in && fin_in) |-> ##2 (re_out == $past(p_in, 2) && im_out == $past(q_in, 2)))
         else $error("final-stage leg did not pass pre-twiddle term");

      // R6
      zero_twiddle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (v_in && !fin_in && c_in == '0 && s_in == '0) |-> ##2 (re_out == '0 && im_out == '0))
         else $error("zero twiddle gave nonzero output");
   end

endmodule

// File: rtl/r4_dif_bfly.sv
module r4_dif_bfly
   import r4_bfly_pkg::*;
#(
   parameter int unsigned DW = 16,
   parameter int unsigned TW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic            final_stage,
   input  logic [2*DW-1:0] in_a,
   input  logic [2*DW-1:0] in_b,
   input  logic [2*DW-1:0] in_c,
   input  logic [2*DW-1:0] in_d,
   input  logic [2*TW-1:0] tw_b,
   input  logic [2*TW-1:0] tw_c,
   input  logic [2*TW-1:0] tw_d,
   output logic            out_valid,
   output logic [2*DW-1:0] out_a,
   output logic [2*DW-1:0] out_b,
   output logic [2*DW-1:0] out_c,
   output logic [2*DW-1:0] out_d
);

   localparam int unsigned PRE_LAT = 2;              // pre-sum pipeline depth
   localparam int unsigned SIDE_W  = 3*2*TW + 1;     // twiddles plus mode

   if (DW < 4 || TW < 2) begin : g_bad_params
      $error("r4_dif_bfly: DW must be >= 4 and TW >= 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) in_ready <= 1'b0;
      else        in_ready <= 1'b1;
   end

   logic take;
   assign take = in_valid && in_ready;

   logic                v2;
   logic [3:0][DW-1:0]  pre_re, pre_im;

   r4_bfly_presum #(.DW(DW)) u_presum (
      .clk    (clk),
      .rst_n  (rst_n),
      .v_in   (take),
      .a      (in_a),
      .b      (in_b),
      .c      (in_c),
      .d      (in_d),
      .v_out  (v2),
      .pre_re (pre_re),
      .pre_im (pre_im)
   );

   // twiddles and mode travel beside the pre-sum stages
   logic [SIDE_W-1:0] side_d, side_q;
   assign side_d = {final_stage, tw_d, tw_c, tw_b};

   r4_bfly_delay #(.W(SIDE_W), .DEPTH(PRE_LAT)) u_side (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (side_d),
      .q     (side_q)
   );

   logic                 fin2;
   logic [3:0][2*TW-1:0] tw2;
   assign fin2   = side_q[SIDE_W-1];
   assign tw2[0] = '0;
   assign tw2[1] = side_q[2*TW-1:0];
   assign tw2[2] = side_q[4*TW-1:2*TW];
   assign tw2[3] = side_q[6*TW-1:4*TW];

   logic [3:0]          leg_v;
   logic [3:0][DW-1:0]  leg_re, leg_im;

   for (genvar k = 0; k < LEGS; k++) begin : g_leg
      r4_bfly_lane #(.DW(DW), .TW(TW), .KIND(leg_kind(k))) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .v_in   (v2),
         .fin_in (fin2),
         .p_in   (pre_re[k]),
         .q_in   (pre_im[k]),
         .c_in   (tw2[k][2*TW-1:TW]),
         .s_in   (tw2[k][TW-1:0]),
         .v_out  (leg_v[k]),
         .re_out (leg_re[k]),
         .im_out (leg_im[k])
      );
   end

   logic unused_v;
   assign unused_v = ^leg_v[3:1];

   assign out_valid = leg_v[0];
   assign out_a = {leg_re[0], leg_im[0]};
   assign out_b = {leg_re[1], leg_im[1]};
   assign out_c = {leg_re[2], leg_im[2]};
   assign out_d = {leg_re[3], leg_im[3]};

   // R9
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid && in_ready, 4))
      else $error("out_valid not four cycles after acceptance");

   // R2
   sum_leg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_a[2*DW-1:DW] == $past(in_a[2*DW-1:DW] + in_b[2*DW-1:DW]
                                              + in_c[2*DW-1:DW] + in_d[2*DW-1:DW], 4)
                  && out_a[DW-1:0] == $past(in_a[DW-1:0] + in_b[DW-1:0]
                                            + in_c[DW-1:0] + in_d[DW-1:0], 4)))
      else $error("output A is not the four-input sum");

   // R1
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> in_ready)
      else $error("in_ready dropped after reset");

endmodule

// File: tb/r4_dif_bfly_test.sv
module r4_dif_bfly_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        final_stage = 1'b0;
   logic [31:0] in_a = '0, in_b = '0, in_c = '0, in_d = '0;
   logic [31:0] tw_b = '0, tw_c = '0, tw_d = '0;
   logic        in_ready, out_valid;
   logic [31:0] out_a, out_b, out_c, out_d;

   always #10 clk = ~clk;   // 50 MHz

   r4_dif_bfly uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .final_stage(final_stage), .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
      .tw_b(tw_b), .tw_c(tw_c), .tw_d(tw_d), .out_valid(out_valid),
      .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d)
   );

   typedef struct {
      logic [3:0][31:0] w;
      int               due;
      string            tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   int   cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // R6: rounded Q15 product rm(x,y)
   function automatic logic [15:0] rm(input logic [15:0] x, input logic [15:0] y);
      logic signed [31:0] p;
      logic [15:0]        h;
      p = $signed({{16{x[15]}}, x}) * $signed({{16{y[15]}}, y});
      h = p[31:16] + {15'b0, p[15]};
      return {h[14:0], 1'b0};
   endfunction

   function automatic logic [31:0] rot(input logic [15:0] p, input logic [15:0] qq,
                                       input logic [31:0] tw, input bit fin);
      logic [15:0] c, s, re, im;
      c = tw[31:16];
      s = tw[15:0];
      if (fin) return {p, qq};               // R7
      re = rm(p, c) + rm(qq, s);
      im = rm(qq, c) - rm(p, s);
      return {re, im};
   endfunction

   // driver: called just after a falling edge; leaves in_valid high
   task automatic send(input logic [31:0] a, b, c, d, tb, tc, td,
                       input bit fin, input string tag);
      exp_t        e;
      logic [15:0] xa, ya, xb, yb, xc, yc, xd, yd;
      logic [15:0] pr, pi;
      {xa, ya} = a; {xb, yb} = b; {xc, yc} = c; {xd, yd} = d;   // R10 packing
      in_valid = 1'b1; final_stage = fin;
      in_a = a; in_b = b; in_c = c; in_d = d;
      tw_b = tb; tw_c = tc; tw_d = td;
      // R2
      pr = xa + xb + xc + xd; pi = ya + yb + yc + yd;
      e.w[0] = {pr, pi};
      // R3
      pr = xa + yb - xc - yd; pi = ya - xb - yc + xd;
      e.w[1] = rot(pr, pi, tb, fin);
      // R4
      pr = xa - xb + xc - xd; pi = ya - yb + yc - yd;
      e.w[2] = rot(pr, pi, tc, fin);
      // R5
      pr = xa - yb - xc + yd; pi = ya + xb - yc - xd;
      e.w[3] = rot(pr, pi, td, fin);
      e.due = cyc + 4;   // R9
      e.tag = tag;
      q.push_back(e);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         while (q.size() > 0 && q[0].due < cyc) begin
            check(1'b0, "R9 missing output", 32'h0, 32'h1);
            void'(q.pop_front());
         end
         if (out_valid) begin
            if (q.size() == 0) begin
               check(1'b0, "R9 unexpected out_valid", 32'h1, 32'h0);
            end else begin
               exp_t e;
               logic [3:0][31:0] act;
               e = q.pop_front();
               act = {out_d, out_c, out_b, out_a};
               check(e.due == cyc, "R9 latency", 32'(cyc), 32'(e.due));
               for (int k = 0; k < 4; k++)
                  check(act[k] === e.w[k], $sformatf("%s out%0d", e.tag, k), act[k], e.w[k]);
            end
         end
      end
   end

   initial begin
      // reset phase, with stray in_valid that must be dropped (R1, R9)
      in_valid = 1'b1;
      repeat (3) @(negedge clk);
      check(in_ready == 1'b0, "R1 ready in reset", {31'b0, in_ready}, 32'h0);
      check(out_valid == 1'b0, "R1 valid in reset", {31'b0, out_valid}, 32'h0);
      check(out_a == 32'h0, "R1 out_a in reset", out_a, 32'h0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R1 ready after reset", {31'b0, in_ready}, 32'h1);
      idle(6);

      // directed: single real impulse, near-unity cosine
      send(32'h0064_0000, 0, 0, 0, 32'h7FFF_0000, 32'h7FFF_0000, 32'h7FFF_0000, 0,
           "R6 unity-cos R3 R4 R5");
      idle(5);
      // directed: zero twiddles in rotate mode
      send(32'h1234_0567, 32'h0F00_F100, 32'hFFEE_0022, 32'h0101_0202, 0, 0, 0, 0,
           "R6 zero-twiddle");
      idle(5);
      // R8: overflow in final-stage mode wraps
      send(32'h7000_7000, 32'h7000_9000, 32'h7000_7000, 32'h9000_7000,
           32'h1234_5678, 32'h4000_4000, 32'h8000_8000, 1, "R8 wrap R7");
      idle(5);
      // R7: twiddles ignored in final mode, back to back with rotate mode
      send(32'h0100_0200, 32'h0030_0040, 32'h0005_0006, 32'h0700_0800,
           32'h5A82_5A82, 32'h0000_7FFF, 32'hA57E_5A82, 1, "R7 ignore-twiddle");
      send(32'h0100_0200, 32'h0030_0040, 32'h0005_0006, 32'h0700_0800,
           32'h5A82_5A82, 32'h0000_7FFF, 32'hA57E_5A82, 0, "R6 eighth-turn");
      idle(5);

      // random streams with gaps, mixed modes (R2..R9)
      for (int i = 0; i < 60; i++) begin
         bit fin;
         fin = (i % 3 == 2);
         send($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
              fin, fin ? "R7 random" : "R6 random");
         if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
      end
      // long back-to-back burst (R9 throughput)
      for (int i = 0; i < 24; i++)
         send($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
              0, "R9 burst");
      idle(12);
      check(q.size() == 0, "R9 drained", 32'(q.size()), 32'h0);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   // watchdog
   initial begin
      #(20 * 20000);
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog expired actual=%08h expected=%08h", 32'h1, 32'h0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule